// File: doc/BRIEF.md
# Serial Bus Receive Packet Filter

This block sits on the receive side of a serial bus link layer, after the bit stream has been assembled into 32-bit quadlets. It follows one packet at a time, framed by a valid strobe and a last-quadlet flag. While the packet streams in, it decodes the transaction code, captures the header fields and runs two CRC-32 accumulators, one over the header and one over the payload. On the cycle after the final quadlet it states a verdict: accept or reject, which receive queue gets the packet, and whether an acknowledge goes back to the sender and with which code.

The acceptance rules are checked in a fixed order. A broken header is dropped silently. Broadcast traffic (isochronous and self-ID) is never acknowledged. Asynchronous packets must be addressed to this node. Requests must pass either the physical-range filter or the per-source request filter, and block requests must respect the maximum payload. A dual-phase retry tracker answers a full receive queue with busy codes of alternating phase. Separately, an acknowledge byte that comes back for a packet this node sent is converted into a transmit event code.

Node ID, both per-source filter masks, the physical range limit and the maximum payload are static register inputs.

Top module: `sbrx_filter`

## Requirements
- R1: A packet's header CRC is the bitwise inverse of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, quadlet bits fed most significant first) over the header quadlets, and it is carried in the quadlet right after them. A mismatch rejects the packet with no acknowledge (dec_ack_send=0, queue code 0).
- R2: An asynchronous packet whose destination ID (quadlet 0 bits 31:16) differs from node_id is rejected with no acknowledge.
- R3: The transaction code is quadlet 0 bits 7:4. Codes 2, 6 and 7 are responses and are accepted into queue 1 with acknowledge 1 (complete). Codes 0, 1, 4 and 5 are requests and are acknowledged with 2 (pending). Any other code except 0xA and 0xE is acknowledged with 0xE (type error) and rejected. Headers are 3 quadlets long for codes 2 and 4, 1 quadlet for 0xA and 0xE, and 4 quadlets otherwise.
- R4: The source node index is quadlet 1 bits 21:16. A request that does not qualify as physical is accepted into queue 2 only if that bit of req_mask is set; otherwise it gets acknowledge 0xE.
- R5: A request whose 48-bit offset ({quadlet 1 bits 15:0, quadlet 2}) is strictly below phys_limit and whose source bit in phys_mask is set goes to queue 3 with acknowledge 2. An offset equal to the limit is outside the range.
- R6: For codes 1 and 5, a data length (quadlet 3 bits 31:16) above max_len gets acknowledge 0xE, and a length equal to max_len is accepted. Responses carry no length limit.
- R7: When payload quadlets follow the header CRC, the last quadlet of the packet is the inverted CRC-32 over the payload quadlets between the two CRCs. A mismatch on an addressed asynchronous packet gets acknowledge 0xD (data error).
- R8: Retry code is quadlet 0 bits 9:8 (0 and 1 mean new, 2 means phase A retry, 3 means phase B retry). An otherwise acceptable packet that meets rxq_busy is rejected with acknowledge 5 (busy A) or 6 (busy B). New packets get the current phase, which is A after reset. A new packet is also refused while a busy answer of the current phase is outstanding.
- R9: A retry is refused only while rxq_busy is high, and then gets the busy code of its own phase. Accepting a retry of the current phase while a busy answer is outstanding flips the phase and clears the outstanding mark.
- R10: Code 0xE (self-ID) with a good header goes to queue 5 and code 0xA (isochronous) with good CRCs goes to queue 4, neither with acknowledge. An isochronous packet with a bad payload CRC is dropped with no acknowledge.
- R11: Rejections are ranked: data CRC, then length, then filter, then busy. A packet rejected by any rank above busy leaves the retry state unchanged.
- R12: An acknowledge byte is valid when bits 3:0 are the inverse of bits 7:4. In that case evt_code is 0x10 plus bits 7:4; otherwise it is 0x0F. The code appears with evt_valid one cycle after ack_rx_valid.
- R13: dec_valid pulses for exactly one cycle, the cycle after the quadlet flagged last, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | Quadlet strobe |
| q_last | input | 1 | Marks the final quadlet of a packet |
| q_data | input | 32 | Received quadlet |
| node_id | input | 16 | This node's bus ID |
| req_mask | input | 64 | Per-source request acceptance |
| phys_mask | input | 64 | Per-source physical acceptance |
| phys_limit | input | 48 | Exclusive upper bound of the physical range |
| max_len | input | 16 | Largest block request length in bytes |
| rxq_busy | input | 1 | Receive queue cannot take a packet |
| ack_rx_valid | input | 1 | Acknowledge byte for a sent packet is present |
| ack_rx | input | 8 | Acknowledge byte with check nibble |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Packet accepted |
| dec_queue | output | 3 | Destination queue (0 none, 1 response, 2 request, 3 physical, 4 isochronous, 5 self-ID) |
| dec_ack_send | output | 1 | An acknowledge must be returned |
| dec_ack | output | 4 | Acknowledge code |
| evt_valid | output | 1 | Transmit event strobe |
| evt_code | output | 5 | Transmit event code |

## Verification
Two functions can land in the same cycle. The verdict for a packet can meet the conversion of a returning acknowledge byte, and one packet can trip several rejection ranks at once. The bench puts an acknowledge byte on the same edge as a packet's last quadlet and checks both outputs on the following cycle. It also sends block requests that carry both an oversized length and a bad payload CRC, and runs filter rejections while the queue is busy; the expected result is the highest rank, with the retry phase left as it was.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;

  localparam int QW    = 32;
  localparam int ID_W  = 16;
  localparam int OFF_W = 48;
  localparam int LEN_W = 16;
  localparam int SRC_W = 6;
  localparam int TC_W  = 4;
  localparam int ACK_W = 4;
  localparam int EVT_W = 5;

  localparam logic [QW-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [QW-1:0] CRC_INIT = '1;

  typedef enum logic [2:0] {
    Q_NONE   = 3'd0,
    Q_RESP   = 3'd1,
    Q_REQ    = 3'd2,
    Q_PHYS   = 3'd3,
    Q_ISO    = 3'd4,
    Q_SELFID = 3'd5
  } queue_e;

  typedef enum logic [ACK_W-1:0] {
    ACK_COMPLETE = 4'h1,
    ACK_PENDING  = 4'h2,
    ACK_BUSY_A   = 4'h5,
    ACK_BUSY_B   = 4'h6,
    ACK_DATA_ERR = 4'hD,
    ACK_TYPE_ERR = 4'hE
  } ack_e;

  typedef enum logic [2:0] {K_REQ, K_RESP, K_ISO, K_SELFID, K_BAD} kind_e;

  typedef struct packed {
    logic [ID_W-1:0]  dest;
    logic [SRC_W-1:0] src;
    logic [OFF_W-1:0] offset;
    logic [LEN_W-1:0] dlen;
    logic [1:0]       rt;
    logic [TC_W-1:0]  tcode;
  } hdr_t;

  function automatic kind_e kind_of(input logic [TC_W-1:0] tc);
    case (tc)
      4'h0, 4'h1, 4'h4, 4'h5: kind_of = K_REQ;
      4'h2, 4'h6, 4'h7:       kind_of = K_RESP;
      4'hA:                   kind_of = K_ISO;
      4'hE:                   kind_of = K_SELFID;
      default:                kind_of = K_BAD;
    endcase
  endfunction

  function automatic logic [2:0] hdr_quads(input logic [TC_W-1:0] tc);
    case (tc)
      4'h2, 4'h4: hdr_quads = 3'd3;
      4'hA, 4'hE: hdr_quads = 3'd1;
      default:    hdr_quads = 3'd4;
    endcase
  endfunction

  function automatic logic len_limited(input logic [TC_W-1:0] tc);
    len_limited = (tc == 4'h1) || (tc == 4'h5);
  endfunction

endpackage

// File: rtl/sbrx_crc.sv
module sbrx_crc #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    POLY = 32'h04C11DB7,
  parameter logic [W-1:0]    INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q, crc_d, seed;

  // one full quadlet folded per clock, most significant bit first
  always_comb begin
    seed  = start ? INIT : crc_q;
    crc_d = seed;
    for (int b = W - 1; b >= 0; b--) begin
      if (crc_d[W-1] ^ din[b]) crc_d = {crc_d[W-2:0], 1'b0} ^ POLY;
      else                     crc_d = {crc_d[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= INIT;
    else if (en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/sbrx_parse.sv
module sbrx_parse
  import sbrx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid,
  input  logic          q_last,
  input  logic [QW-1:0] q_data,
  output hdr_t          hdr,
  output logic          hdr_good,
  output logic          data_good
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q, idx_d, hl, hl_p1;
  hdr_t             hdr_q, hdr_d;
  logic             hok_q, hok_d;
  logic [TC_W-1:0]  tc_now;
  logic [QW-1:0]    crc_h, crc_p;
  logic             h_en, h_start, p_en, p_start;

  assign tc_now  = (idx_q == '0) ? q_data[7:4] : hdr_q.tcode;
  assign hl      = IDX_W'(hdr_quads(tc_now));
  assign hl_p1   = hl + 1'b1;

  assign h_en    = q_valid && (idx_q < hl);
  assign h_start = (idx_q == '0);
  assign p_en    = q_valid && !q_last && (idx_q > hl);
  assign p_start = (idx_q == hl_p1);

  sbrx_crc #(.W(QW), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc_hdr (
    .clk(clk), .rst_n(rst_n), .en(h_en), .start(h_start), .din(q_data), .crc(crc_h)
  );

  sbrx_crc #(.W(QW), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc_pay (
    .clk(clk), .rst_n(rst_n), .en(p_en), .start(p_start), .din(q_data), .crc(crc_p)
  );

  always_comb begin
    hdr_d = hdr_q;
    hok_d = hok_q;
    idx_d = idx_q;
    if (q_valid) begin
      if (q_last)                idx_d = '0;
      else if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
      if (idx_q < hl) begin
        case (idx_q)
          IDX_W'(0): begin
            hdr_d.dest  = q_data[31:16];
            hdr_d.dlen  = q_data[31:16];
            hdr_d.rt    = q_data[9:8];
            hdr_d.tcode = q_data[7:4];
          end
          IDX_W'(1): begin
            hdr_d.src                = q_data[16 +: SRC_W];
            hdr_d.offset[OFF_W-1:32] = q_data[15:0];
          end
          IDX_W'(2): hdr_d.offset[31:0] = q_data;
          IDX_W'(3): hdr_d.dlen         = q_data[31:16];
          default: ;
        endcase
      end
      if (idx_q == hl) hok_d = (q_data == ~crc_h);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      hdr_q <= '0;
      hok_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      hdr_q <= hdr_d;
      hok_q <= hok_d;
    end
  end

  // verdict inputs, meaningful in the cycle that carries the last quadlet
  always_comb begin
    if (idx_q == hl) hdr_good = (q_data == ~crc_h);
    else             hdr_good = (idx_q > hl) && hok_q;
    if (idx_q <= hl)        data_good = 1'b1;
    else if (idx_q == hl_p1) data_good = (q_data == ~CRC_INIT);
    else                     data_good = (q_data == ~crc_p);
  end

  assign hdr = hdr_q;

endmodule

// File: rtl/sbrx_retry.sv
module sbrx_retry
  import sbrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic [1:0]       rt,
  input  logic             busy,
  output logic             allow,
  output logic [ACK_W-1:0] busy_ack
);

  logic phase_q, phase_d, pend_q, pend_d;
  logic is_new, letter;

  assign is_new = !rt[1];
  assign letter = rt[0];

  always_comb begin
    if (is_new) begin
      allow    = !busy && !pend_q;
      busy_ack = phase_q ? ACK_BUSY_B : ACK_BUSY_A;
    end else begin
      allow    = !busy;
      busy_ack = letter ? ACK_BUSY_B : ACK_BUSY_A;
    end
    phase_d = phase_q;
    pend_d  = pend_q;
    if (apply) begin
      if (!allow) begin
        if (is_new || (letter == phase_q)) pend_d = 1'b1;
      end else if (!is_new && (letter == phase_q) && pend_q) begin
        phase_d = !phase_q;
        pend_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
    end
  end

  // R9: the phase only moves when a retry packet is let through
  a_r9_phase_on_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> $past(apply && allow && !is_new));

  // R8: the outstanding mark is only raised by a busy refusal
  a_r8_pend_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(apply && !allow));

endmodule

// File: rtl/sbrx_evt.sv
module sbrx_evt
  import sbrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  input  logic [7:0]       ack_byte,
  output logic             evt_valid,
  output logic [EVT_W-1:0] evt_code
);

  localparam logic [EVT_W-1:0] EVT_BAD_ACK = 5'h0F;

  logic             vld_q;
  logic [EVT_W-1:0] code_q, code_d;

  always_comb begin
    if (ack_byte[3:0] == ~ack_byte[7:4]) code_d = {1'b1, ack_byte[7:4]};
    else                                 code_d = EVT_BAD_ACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q <= ack_valid;
      if (ack_valid) code_q <= code_d;
    end
  end

  assign evt_valid = vld_q;
  assign evt_code  = code_q;

  // R12: one event per acknowledge byte, one cycle later
  a_r12_evt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> evt_valid);
  a_r12_evt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !evt_valid);

endmodule

// File: rtl/sbrx_filter.sv
module sbrx_filter
  import sbrx_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_valid,
  input  logic             q_last,
  input  logic [31:0]      q_data,
  input  logic [15:0]      node_id,
  input  logic [63:0]      req_mask,
  input  logic [63:0]      phys_mask,
  input  logic [47:0]      phys_limit,
  input  logic [15:0]      max_len,
  input  logic             rxq_busy,
  input  logic             ack_rx_valid,
  input  logic [7:0]       ack_rx,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic [2:0]       dec_queue,
  output logic             dec_ack_send,
  output logic [3:0]       dec_ack,
  output logic             evt_valid,
  output logic [4:0]       evt_code
);

  // reset asserted at once, released through two flops
  logic rst_meta, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i_n  <= rst_meta;
    end
  end

  hdr_t             hdr;
  logic             hdr_good, data_good, pkt_end;
  logic             r_apply, r_allow;
  logic [ACK_W-1:0] r_busy_ack;
  kind_e            kind;
  logic             phys_hit, req_ok, too_long;

  assign pkt_end = q_valid && q_last;

  sbrx_parse #(.IDX_W(IDX_W)) i_parse (
    .clk(clk), .rst_n(rst_i_n), .q_valid(q_valid), .q_last(q_last), .q_data(q_data),
    .hdr(hdr), .hdr_good(hdr_good), .data_good(data_good)
  );

  assign kind     = kind_of(hdr.tcode);
  assign req_ok   = req_mask[hdr.src];
  assign phys_hit = (kind == K_REQ) && (hdr.offset < phys_limit) && phys_mask[hdr.src];
  assign too_long = len_limited(hdr.tcode) && (hdr.dlen > max_len);

  // verdict, evaluated against the quadlet flagged last
  logic             acc_d, send_d, stage_retry;
  queue_e           que_d;
  logic [ACK_W-1:0] ack_d;

  always_comb begin
    acc_d       = 1'b0;
    send_d      = 1'b0;
    que_d       = Q_NONE;
    ack_d       = ACK_TYPE_ERR;
    stage_retry = 1'b0;
    if (!hdr_good) begin
      acc_d = 1'b0;
    end else if (kind == K_SELFID) begin
      acc_d = 1'b1;
      que_d = Q_SELFID;
    end else if (kind == K_ISO) begin
      acc_d = data_good;
      que_d = data_good ? Q_ISO : Q_NONE;
    end else if (hdr.dest != node_id) begin
      acc_d = 1'b0;
    end else begin
      send_d = 1'b1;
      if (kind == K_BAD)                            ack_d = ACK_TYPE_ERR;
      else if (!data_good)                          ack_d = ACK_DATA_ERR;
      else if (too_long)                            ack_d = ACK_TYPE_ERR;
      else if ((kind == K_REQ) && !phys_hit && !req_ok) ack_d = ACK_TYPE_ERR;
      else begin
        stage_retry = 1'b1;
        if (!r_allow) begin
          ack_d = r_busy_ack;
        end else begin
          acc_d = 1'b1;
          if (kind == K_RESP) begin
            que_d = Q_RESP;
            ack_d = ACK_COMPLETE;
          end else begin
            que_d = phys_hit ? Q_PHYS : Q_REQ;
            ack_d = ACK_PENDING;
          end
        end
      end
    end
  end

  assign r_apply = pkt_end && stage_retry;

  sbrx_retry i_retry (
    .clk(clk), .rst_n(rst_i_n), .apply(r_apply), .rt(hdr.rt), .busy(rxq_busy),
    .allow(r_allow), .busy_ack(r_busy_ack)
  );

  sbrx_evt i_evt (
    .clk(clk), .rst_n(rst_i_n), .ack_valid(ack_rx_valid), .ack_byte(ack_rx),
    .evt_valid(evt_valid), .evt_code(evt_code)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dec_valid    <= 1'b0;
      dec_accept   <= 1'b0;
      dec_queue    <= Q_NONE;
      dec_ack_send <= 1'b0;
      dec_ack      <= '0;
    end else begin
      dec_valid <= pkt_end;
      if (pkt_end) begin
        dec_accept   <= acc_d;
        dec_queue    <= que_d;
        dec_ack_send <= send_d;
        dec_ack      <= ack_d;
      end
    end
  end

  // R13: verdict strobe tracks the last quadlet by one cycle
  a_r13_verdict_follows: assert property (@(posedge clk) disable iff (!rst_i_n)
    pkt_end |=> dec_valid);
  a_r13_verdict_single: assert property (@(posedge clk) disable iff (!rst_i_n)
    !pkt_end |=> !dec_valid);

  // R1: a broken header never produces an acknowledge
  a_r1_silent_drop: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pkt_end && !hdr_good) |=> (dec_valid && !dec_accept && !dec_ack_send));

  // R3: accepted packets name a queue, rejected ones do not
  a_r3_queue_agrees: assert property (@(posedge clk) disable iff (!rst_i_n)
    dec_valid |-> (dec_accept == (dec_queue != Q_NONE)));

  // R10: broadcast queues are never acknowledged
  a_r10_bcast_noack: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dec_valid && ((dec_queue == Q_ISO) || (dec_queue == Q_SELFID))) |-> !dec_ack_send);

endmodule

// File: tb/test_sbrx_filter.sv
module test_sbrx_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        q_valid, q_last;
  logic [31:0] q_data;
  logic [15:0] node_id, max_len;
  logic [63:0] req_mask, phys_mask;
  logic [47:0] phys_limit;
  logic        rxq_busy, ack_rx_valid;
  logic [7:0]  ack_rx;
  logic        dec_valid, dec_accept, dec_ack_send, evt_valid;
  logic [2:0]  dec_queue;
  logic [3:0]  dec_ack;
  logic [4:0]  evt_code;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sbrx_filter i_sbrx_filter (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_last(q_last), .q_data(q_data),
    .node_id(node_id), .req_mask(req_mask), .phys_mask(phys_mask),
    .phys_limit(phys_limit), .max_len(max_len), .rxq_busy(rxq_busy),
    .ack_rx_valid(ack_rx_valid), .ack_rx(ack_rx),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_queue(dec_queue),
    .dec_ack_send(dec_ack_send), .dec_ack(dec_ack),
    .evt_valid(evt_valid), .evt_code(evt_code)
  );

  localparam logic [15:0] ME    = 16'hFFC2;
  localparam logic [15:0] SRC_A = 16'hFFC5;   // request bit set, physical bit clear
  localparam logic [15:0] SRC_B = 16'hFFC6;   // request bit clear, physical bit set
  localparam logic [47:0] LIMIT = 48'h0001_0000_0000;
  localparam logic [47:0] LOW   = 48'h0000_0000_1000;
  localparam logic [47:0] HIGH  = 48'hFFFF_F000_0400;

  logic [31:0] pk [0:31];
  int          pn;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bcrc(input int from, input int upto);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int q = from; q < upto; q++)
      for (int b = 31; b >= 0; b--)
        if (c[31] ^ pk[q][b]) c = (c << 1) ^ 32'h04C1_1DB7;
        else                  c = c << 1;
    return ~c;
  endfunction

  task automatic add_payload(input int first, input int nd, input bit bad_d);
    if (nd > 0) begin
      for (int k = 0; k < nd; k++) begin
        pk[pn] = 32'hC0DE_0000 + k;
        pn++;
      end
      pk[pn] = bcrc(first, pn) ^ {31'd0, bad_d};
      pn++;
    end
  endtask

  task automatic build_async(input logic [3:0] tc, input logic [15:0] dest,
                             input logic [15:0] src, input logic [47:0] off,
                             input logic [1:0] rt, input logic [15:0] dl,
                             input int nd, input bit bad_h, input bit bad_d);
    int hl;
    hl = (tc == 4'h2 || tc == 4'h4) ? 3 : 4;
    pk[0]  = {dest, 6'd9, rt, tc, 4'd0};
    pk[1]  = {src, off[47:32]};
    pk[2]  = off[31:0];
    pk[3]  = {dl, 16'h0};
    pk[hl] = bcrc(0, hl) ^ {31'd0, bad_h};
    pn     = hl + 1;
    add_payload(hl + 1, nd, bad_d);
  endtask

  task automatic build_bcast(input logic [3:0] tc, input logic [15:0] top,
                             input int nd, input bit bad_d);
    pk[0] = {top, 8'h3C, tc, 4'd0};
    pk[1] = bcrc(0, 1);
    pn    = 2;
    add_payload(2, nd, bad_d);
  endtask

  task automatic send(input bit with_ack, input logic [7:0] ab);
    for (int i = 0; i < pn; i++) begin
      @(negedge clk);
      q_valid = 1'b1;
      q_data  = pk[i];
      q_last  = (i == pn - 1);
      if (with_ack && (i == pn - 1)) begin
        ack_rx_valid = 1'b1;
        ack_rx       = ab;
      end
    end
    @(negedge clk);
    q_valid      = 1'b0;
    q_last       = 1'b0;
    ack_rx_valid = 1'b0;
  endtask

  task automatic expect_dec(input string tag, input bit acc, input logic [2:0] q,
                            input bit snd, input logic [3:0] ack);
    check({tag, " valid"},  {31'd0, dec_valid}, 32'd1);
    check({tag, " accept"}, {31'd0, dec_accept}, {31'd0, acc});
    check({tag, " queue"},  {29'd0, dec_queue}, {29'd0, q});
    check({tag, " acksend"}, {31'd0, dec_ack_send}, {31'd0, snd});
    if (snd) check({tag, " ack"}, {28'd0, dec_ack}, {28'd0, ack});
  endtask

  task automatic t_reset;
    check("R13 reset dec_valid", {31'd0, dec_valid}, 32'd0);
    check("R12 reset evt_valid", {31'd0, evt_valid}, 32'd0);
  endtask

  task automatic t_responses;
    build_async(4'h2, ME, SRC_A, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R3 write response", 1'b1, 3'd1, 1'b1, 4'h1);
    @(negedge clk);
    check("R13 single pulse", {31'd0, dec_valid}, 32'd0);
    build_async(4'h7, ME, SRC_B, HIGH, 2'd0, 16'd200, 3, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R6 R3 long block response", 1'b1, 3'd1, 1'b1, 4'h1);
  endtask

  task automatic t_requests;
    build_async(4'h0, ME, SRC_A, HIGH, 2'd0, 16'h1234, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R4 request filter pass", 1'b1, 3'd2, 1'b1, 4'h2);
    build_async(4'h4, ME, SRC_B, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R4 request filter block", 1'b0, 3'd0, 1'b1, 4'hE);
    build_async(4'h3, ME, SRC_A, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R3 unknown tcode", 1'b0, 3'd0, 1'b1, 4'hE);
  endtask

  task automatic t_physical;
    build_async(4'h5, ME, SRC_B, LOW, 2'd0, 16'd16, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R5 physical in range", 1'b1, 3'd3, 1'b1, 4'h2);
    build_async(4'h0, ME, SRC_A, LOW, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R5 physical bit clear", 1'b1, 3'd2, 1'b1, 4'h2);
    build_async(4'h0, ME, SRC_B, LIMIT, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R5 offset at limit", 1'b0, 3'd0, 1'b1, 4'hE);
  endtask

  task automatic t_address_and_hcrc;
    build_async(4'h0, 16'hFFC3, SRC_A, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R2 other node", 1'b0, 3'd0, 1'b0, 4'h0);
    build_async(4'h1, ME, SRC_A, HIGH, 2'd0, 16'd8, 2, 1'b1, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R1 header crc", 1'b0, 3'd0, 1'b0, 4'h0);
  endtask

  task automatic t_length_and_dcrc;
    build_async(4'h1, ME, SRC_A, HIGH, 2'd0, 16'd64, 16, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R6 length at max", 1'b1, 3'd2, 1'b1, 4'h2);
    build_async(4'h1, ME, SRC_A, HIGH, 2'd0, 16'd68, 17, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R6 length over max", 1'b0, 3'd0, 1'b1, 4'hE);
    build_async(4'h7, ME, SRC_A, HIGH, 2'd0, 16'd8, 2, 1'b0, 1'b1);
    send(1'b0, 8'h0);
    expect_dec("R7 data crc", 1'b0, 3'd0, 1'b1, 4'hD);
    build_async(4'h1, ME, SRC_B, HIGH, 2'd0, 16'd68, 17, 1'b0, 1'b1);
    send(1'b0, 8'h0);
    expect_dec("R11 data crc over length and filter", 1'b0, 3'd0, 1'b1, 4'hD);
  endtask

  task automatic t_retry;
    rxq_busy = 1'b1;
    build_async(4'h0, ME, SRC_A, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R8 busy new phase A", 1'b0, 3'd0, 1'b1, 4'h5);
    rxq_busy = 1'b0;
    build_async(4'h0, ME, SRC_A, HIGH, 2'd1, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R8 new held while outstanding", 1'b0, 3'd0, 1'b1, 4'h5);
    build_async(4'h0, ME, SRC_A, HIGH, 2'd2, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R9 retry A accepted", 1'b1, 3'd2, 1'b1, 4'h2);
    rxq_busy = 1'b1;
    build_async(4'h2, ME, SRC_A, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R9 busy new phase B", 1'b0, 3'd0, 1'b1, 4'h6);
    build_async(4'h0, ME, SRC_A, HIGH, 2'd2, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R9 busy retry A keeps letter", 1'b0, 3'd0, 1'b1, 4'h5);
    rxq_busy = 1'b0;
    build_async(4'h0, ME, SRC_A, HIGH, 2'd3, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R9 retry B accepted", 1'b1, 3'd2, 1'b1, 4'h2);
    rxq_busy = 1'b1;
    build_async(4'h0, ME, SRC_B, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R11 filter outranks busy", 1'b0, 3'd0, 1'b1, 4'hE);
    rxq_busy = 1'b0;
    build_async(4'h0, ME, SRC_A, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R11 retry state untouched", 1'b1, 3'd2, 1'b1, 4'h2);
  endtask

  task automatic t_broadcast;
    build_bcast(4'hA, 16'd8, 2, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R10 isochronous", 1'b1, 3'd4, 1'b0, 4'h0);
    build_bcast(4'hA, 16'd8, 2, 1'b1);
    send(1'b0, 8'h0);
    expect_dec("R10 isochronous bad payload", 1'b0, 3'd0, 1'b0, 4'h0);
    build_bcast(4'hE, 16'h7F41, 0, 1'b0);
    send(1'b0, 8'h0);
    expect_dec("R10 self-id", 1'b1, 3'd5, 1'b0, 4'h0);
  endtask

  task automatic t_events;
    @(negedge clk);
    ack_rx_valid = 1'b1;
    ack_rx       = 8'h1E;
    @(negedge clk);
    ack_rx_valid = 1'b0;
    check("R12 good ack valid", {31'd0, evt_valid}, 32'd1);
    check("R12 good ack code", {27'd0, evt_code}, 32'h11);
    @(negedge clk);
    check("R12 no ack no event", {31'd0, evt_valid}, 32'd0);
    build_async(4'h6, ME, SRC_A, HIGH, 2'd0, 16'd0, 0, 1'b0, 1'b0);
    send(1'b1, 8'h43);
    expect_dec("R13 verdict beside event", 1'b1, 3'd1, 1'b1, 4'h1);
    check("R12 bad ack valid", {31'd0, evt_valid}, 32'd1);
    check("R12 bad ack code", {27'd0, evt_code}, 32'h0F);
  endtask

  initial begin
    rst_n        = 1'b0;
    q_valid      = 1'b0;
    q_last       = 1'b0;
    q_data       = '0;
    node_id      = ME;
    req_mask     = 64'd1 << 5;
    phys_mask    = 64'd1 << 6;
    phys_limit   = LIMIT;
    max_len      = 16'd64;
    rxq_busy     = 1'b0;
    ack_rx_valid = 1'b0;
    ack_rx       = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_responses();
    t_requests();
    t_physical();
    t_address_and_hcrc();
    t_length_and_dcrc();
    t_retry();
    t_broadcast();
    t_events();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule